// File: doc/BRIEF.md
# Radix-N Nibble Subtractor with Borrow

This block subtracts a 4-bit subtrahend and an incoming borrow bit from a 4-bit minuend, then corrects the difference to a radix chosen at run time. The radix can be any value from 1 to 16. A radix of 10 gives packed-decimal digit arithmetic, and a radix of 16 gives plain binary nibble arithmetic. The block returns the corrected digit, a borrow flag for the next digit of a multi-digit subtraction, and a zero flag. Operand fetch, result write-back and all other status flags belong to the surrounding datapath.

Operands enter as a single transfer on a valid/ready input channel. Each result leaves on a valid/ready output channel after one register stage. Back-pressure works as follows. The input is ready whenever the output stage is empty or is being drained in the same cycle. While the output is valid and not taken, the result and its flags stay frozen and no new operands are accepted. A held result and a new operand set can change places in one clock edge, so a stream with no stalls moves one digit per cycle.

Top module: `rsub_unit`

## Requirements
- R1: If minuend minus subtrahend minus incoming borrow is zero or more, the result is the low 4 bits of that difference and the borrow flag is 0.
- R2: If that difference is negative, the result is the low 4 bits of (difference + N) and the borrow flag is 1.
- R3: The 4-bit radix field selects N. The value 0000 means N = 16, and any other value k means N = k.
- R4: The zero flag is 1 exactly when the 4-bit result is 0000.
- R5: With the radix field at 0000, {borrow, result} equals the 5-bit two's-complement value of minuend - subtrahend - incoming borrow.
- R6: Operands at or above N raise no error. R1 and R2 still apply unchanged (for example 12 - 0 at N = 10 gives 12 with borrow 0, and 3 - 14 - 1 at N = 10 gives 14 with borrow 1).
- R7: An input transfer happens when in_valid and in_ready are both 1. Its result is presented with out_valid = 1 after the next rising clock edge. in_ready is 0 whenever out_valid is 1 and out_ready is 0.
- R8: While out_valid is 1 and out_ready is 0, out_valid, the result and both flags hold their values, and offered operands are not taken.
- R9: While rst_n is low, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set can be taken this cycle |
| in_min | input | 4 | Minuend digit |
| in_sub | input | 4 | Subtrahend digit |
| in_borrow | input | 1 | Incoming borrow |
| in_radix | input | 4 | Radix field (0000 selects 16) |
| out_valid | output | 1 | Result held on the output |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_diff | output | 4 | Radix-corrected result digit |
| out_borrow | output | 1 | Outgoing borrow flag |
| out_zero | output | 1 | Result-is-zero flag |

## Verification
The bench builds the block with its default digit width of 4, the only width the requirements define. At that width the whole operand space of 16 × 16 × 2 × 16 combinations can be reached. Random draws cover every radix, including N = 1 and the 0000 encoding of 16. Directed cases cover the extremes: 0 - 15 - 1 at each small radix, operands above the radix, and results that land exactly on zero. Separate directed sequences hold out_ready low to exercise the stall path, and then release it while new operands are waiting to test the swap in a single edge.

// File: rtl/rsub_pkg.sv
package rsub_pkg;
  // Digit width of the subtractor; the radix field shares it.
  localparam int unsigned NIB_W = 4;

  // Widen a radix field to the radix value, field of all zeros meaning 2**w.
  function automatic logic [NIB_W:0] radix_value(input logic [NIB_W-1:0] field);
    if (field == '0) radix_value = {1'b1, {NIB_W{1'b0}}};
    else             radix_value = {1'b0, field};
  endfunction
endpackage

// File: rtl/rsub_radix_dec.sv
module rsub_radix_dec #(
  parameter int unsigned W = rsub_pkg::NIB_W
) (
  input  logic [W-1:0] field,
  output logic [W:0]   radix
);
  localparam logic [W:0] FULL_RADIX = {1'b1, {W{1'b0}}};

  generate
    if (W == rsub_pkg::NIB_W) begin : g_pkg
      always_comb radix = rsub_pkg::radix_value(field);
    end else begin : g_generic
      always_comb radix = (field == '0) ? FULL_RADIX : {1'b0, field};
    end
  endgenerate
endmodule

// File: rtl/rsub_core.sv
module rsub_core #(
  parameter int unsigned W = rsub_pkg::NIB_W
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  input  logic         borrow_in,
  input  logic [W:0]   radix,
  output logic [W-1:0] diff,
  output logic         borrow_out,
  output logic         zero
);
  // Two guard bits: one for the radix width, one for the sign.
  localparam int unsigned SW = W + 2;

  logic signed [SW-1:0] raw;
  logic signed [SW-1:0] fixed;

  always_comb begin
    raw = $signed({2'b00, minuend}) - $signed({2'b00, subtrahend})
        - $signed({{(SW-1){1'b0}}, borrow_in});
    borrow_out = raw[SW-1];
    // Negative difference: pull it back into range by one radix step.
    fixed = borrow_out ? raw + $signed({1'b0, radix}) : raw;
    diff = fixed[W-1:0];
    zero = (diff == '0);
  end
endmodule

// File: rtl/rsub_stage.sv
module rsub_stage #(
  parameter int unsigned PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] d,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] q
);
  logic          full;
  logic [PW-1:0] hold;

  assign in_ready  = !full || out_ready;
  assign out_valid = full;
  assign q         = hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else if (in_ready) begin
      full <= in_valid;
      if (in_valid) hold <= d;
    end
  end
endmodule

// File: rtl/rsub_unit.sv
module rsub_unit #(
  parameter int unsigned W = rsub_pkg::NIB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_min,
  input  logic [W-1:0] in_sub,
  input  logic         in_borrow,
  input  logic [W-1:0] in_radix,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_diff,
  output logic         out_borrow,
  output logic         out_zero
);
  localparam int unsigned PW = W + 2;

  logic [W:0]    radix;
  logic [W-1:0]  c_diff;
  logic          c_borrow;
  logic          c_zero;
  logic [PW-1:0] q;

  rsub_radix_dec #(.W(W)) u_dec (
    .field (in_radix),
    .radix (radix)
  );

  rsub_core #(.W(W)) u_core (
    .minuend    (in_min),
    .subtrahend (in_sub),
    .borrow_in  (in_borrow),
    .radix      (radix),
    .diff       (c_diff),
    .borrow_out (c_borrow),
    .zero       (c_zero)
  );

  rsub_stage #(.PW(PW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         ({c_borrow, c_zero, c_diff}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (q)
  );

  assign out_borrow = q[PW-1];
  assign out_zero   = q[PW-2];
  assign out_diff   = q[W-1:0];
endmodule

// File: rtl/rsub_unit_chk.sv
module rsub_unit_chk #(
  parameter int unsigned W = rsub_pkg::NIB_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_min,
  input logic [W-1:0] in_sub,
  input logic         in_borrow,
  input logic [W-1:0] in_radix,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_diff,
  input logic         out_borrow,
  input logic         out_zero
);
  logic         take;
  logic [W:0]   bin_diff;
  logic         no_borrow;

  assign take      = in_valid && in_ready;
  assign bin_diff  = {1'b0, in_min} - {1'b0, in_sub} - {{W{1'b0}}, in_borrow};
  assign no_borrow = ({1'b0, in_min} >= ({1'b0, in_sub} + {{W{1'b0}}, in_borrow}));

  // R1
  nonneg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && no_borrow |=> out_valid && !out_borrow);

  // R2
  neg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !no_borrow |=> out_valid && out_borrow);

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_diff == '0)));

  // R5
  binary_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_radix == '0) |=> {out_borrow, out_diff} == $past(bin_diff));

  // R7
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_diff)
      && $stable(out_borrow) && $stable(out_zero));

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind rsub_unit rsub_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_min     (in_min),
  .in_sub     (in_sub),
  .in_borrow  (in_borrow),
  .in_radix   (in_radix),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_diff   (out_diff),
  .out_borrow (out_borrow),
  .out_zero   (out_zero)
);

// File: tb/rsub_unit_bench.sv
module rsub_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_min = '0;
  logic [3:0] in_sub = '0;
  logic       in_borrow = 1'b0;
  logic [3:0] in_radix = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [3:0] out_diff;
  logic       out_borrow;
  logic       out_zero;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rsub_unit u_rsub_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_min(in_min), .in_sub(in_sub), .in_borrow(in_borrow), .in_radix(in_radix),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_diff(out_diff), .out_borrow(out_borrow), .out_zero(out_zero)
  );

  // Expected {borrow, zero, diff} from the requirements.
  function automatic logic [5:0] model(input logic [3:0] a, input logic [3:0] b,
                                       input logic c, input logic [3:0] f);
    int n;
    int raw;
    logic br;
    logic [3:0] r;
    n   = (f == 4'd0) ? 16 : int'(f);
    raw = int'(a) - int'(b) - int'(c);
    br  = (raw < 0);
    if (br) raw = raw + n;
    r = raw[3:0];
    model = {br, (r == 4'd0), r};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_out(input logic [3:0] a, input logic [3:0] b,
                           input logic c, input logic [3:0] f);
    logic [5:0] e;
    string tag;
    e = model(a, b, c, f);
    if (f == 4'd0) tag = "R5";
    else if (a >= f || b >= f) tag = "R6";
    else if (e[5]) tag = "R2";
    else tag = "R1";
    check({tag, " valid"}, 32'(out_valid), 32'd1);
    check({tag, " diff/borrow"}, 32'({out_borrow, out_diff}), 32'({e[5], e[3:0]}));
    check("R4 zero", 32'(out_zero), 32'(e[4]));
  endtask

  task automatic xfer(input logic [3:0] a, input logic [3:0] b,
                      input logic c, input logic [3:0] f);
    @(negedge clk);
    in_min = a; in_sub = b; in_borrow = c; in_radix = f;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    check_out(a, b, c, f);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 out_valid in reset", 32'(out_valid), 32'd0);
    check("R9 in_ready in reset", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed corners
    xfer(4'd5, 4'd3, 1'b0, 4'd10);   // R1: 2
    xfer(4'd3, 4'd5, 1'b0, 4'd10);   // R2: 8
    xfer(4'd0, 4'd0, 1'b1, 4'd10);   // R2: 9
    xfer(4'd7, 4'd7, 1'b0, 4'd10);   // R4: zero
    xfer(4'd0, 4'd15, 1'b1, 4'd0);   // R3/R5: N=16, 0
    xfer(4'd0, 4'd1, 1'b0, 4'd0);    // R5: 15
    xfer(4'd0, 4'd1, 1'b0, 4'd1);    // R3: N=1 gives 0
    xfer(4'd0, 4'd15, 1'b1, 4'd1);   // R3: -16+1 -> 1
    xfer(4'd12, 4'd0, 1'b0, 4'd10);  // R6: 12, no borrow
    xfer(4'd3, 4'd14, 1'b1, 4'd10);  // R6: 14 with borrow
    xfer(4'd0, 4'd3, 1'b0, 4'd3);    // R4: wraps to zero with borrow

    // Random sweep
    for (int i = 0; i < 400; i++) begin
      xfer(4'($urandom), 4'($urandom), 1'($urandom), 4'($urandom));
    end

    // R8 stall then R7 swap on one edge
    @(negedge clk);
    in_min = 4'd2; in_sub = 4'd6; in_borrow = 1'b0; in_radix = 4'd10;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check_out(4'd2, 4'd6, 1'b0, 4'd10);
    in_min = 4'd9; in_sub = 4'd1; in_borrow = 1'b1; in_radix = 4'd0;
    check("R7 in_ready low while stalled", 32'(in_ready), 32'd0);
    repeat (3) @(negedge clk);
    check("R8 diff held", 32'({out_borrow, out_diff}), 32'({1'b1, 4'd6}));
    check("R8 valid held", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    check_out(4'd9, 4'd1, 1'b1, 4'd0);
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 drained", 32'(out_valid), 32'd0);
    check("R7 ready when empty", 32'(in_ready), 32'd1);

    // R9 reset mid-stream
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R9 reset clears output", 32'(out_valid), 32'd0);
    check("R9 ready in reset", 32'(in_ready), 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule